// File: doc/BRIEF.md
# RISC-V Immediate Field Extractor

This combinational block takes one 32-bit RISC-V instruction word and builds the
immediate for every format that carries one: I, S, B, U and J. The bits of each
immediate are spread across the word. The block collects them in the right
order and sign-extends each result to the full data width, which is 64 bits by
default.

All five immediates are available at the same time, each on its own port. The
block does not look at the opcode and does not check whether the word is a
valid instruction. A multiplexer further down the datapath, driven by the
instruction decoder, picks the immediate it needs. For example, the ALU
B-operand multiplexer takes the I-format value, and the branch and jump target
adder takes the B or J value.

Top module: `rv_imm_extract`

## Requirements
- R1: `imm_i` equals word bits [31:20], treated as a 12-bit signed value and sign-extended to XLEN bits.
- R2: `imm_s` equals the 12-bit signed value whose bits [11:5] are word bits [31:25] and whose bits [4:0] are word bits [11:7], sign-extended to XLEN bits.
- R3: `imm_b` equals the 13-bit signed value with bit 12 = word bit 31, bit 11 = word bit 7, bits [10:5] = word bits [30:25], bits [4:1] = word bits [11:8] and bit 0 = 0, sign-extended to XLEN bits.
- R4: `imm_u` equals word bits [31:12] placed in bits [31:12], with bits [11:0] zero, sign-extended from bit 31 to XLEN bits.
- R5: `imm_j` equals the 21-bit signed value with bit 20 = word bit 31, bits [19:12] = word bits [19:12], bit 11 = word bit 20, bits [10:1] = word bits [30:21] and bit 0 = 0, sign-extended to XLEN bits.
- R6: Every output bit above the top bit of its format's immediate equals word bit 31. When that bit is 1, all those upper bits are ones.
- R7: The opcode bits [6:0] of the word have no effect on any output.
- R8: The block has no clock and no state. All five outputs follow a change of the word within the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| iw | input | 32 | Instruction word |
| imm_i | output | XLEN (64) | I-format immediate, sign-extended |
| imm_s | output | XLEN (64) | S-format immediate, sign-extended |
| imm_b | output | XLEN (64) | B-format branch offset, sign-extended |
| imm_u | output | XLEN (64) | U-format upper immediate, sign-extended |
| imm_j | output | XLEN (64) | J-format jump offset, sign-extended |

## Verification
The bench applies words with exactly one bit set at each field boundary: bits 7, 8, 12, 20, 21 and 25. A bit routed to the wrong place shows up as one misplaced power of two on a single port. Swapping word bit 7 and word bit 31 in the B offset, or bit 20 and the bits [19:12] in the J offset, would move one set bit and break that row. The all-ones and sign-bit-only words target the extension width. Extending from the wrong bit, or leaving bit 0 or the low U bits non-zero, changes the upper word or the lowest bits. Flipping only the opcode bits checks that no output depends on them. A long pseudo-random sweep against a model built from the requirements catches any remaining wiring mistake.

// File: rtl/rv_imm_extract.sv
module rv_imm_extract #(
  parameter int XLEN = 64
) (
  input  logic [31:0]     iw,
  output logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] imm_s,
  output logic [XLEN-1:0] imm_b,
  output logic [XLEN-1:0] imm_u,
  output logic [XLEN-1:0] imm_j
);
  localparam int W_I = 12;
  localparam int W_S = 12;
  localparam int W_B = 13;
  localparam int W_U = 32;
  localparam int W_J = 21;

  logic          sgn;
  logic [W_I-1:0] raw_i;
  logic [W_S-1:0] raw_s;
  logic [W_B-1:0] raw_b;
  logic [W_U-1:0] raw_u;
  logic [W_J-1:0] raw_j;
  logic [6:0]     unused_opcode;

  assign unused_opcode = iw[6:0];
  assign sgn   = iw[31];

  assign raw_i = iw[31:20];
  assign raw_s = {iw[31:25], iw[11:7]};
  assign raw_b = {iw[31], iw[7], iw[30:25], iw[11:8], 1'b0};
  assign raw_u = {iw[31:12], 12'b0};
  assign raw_j = {iw[31], iw[19:12], iw[20], iw[30:21], 1'b0};

  assign imm_i = {{(XLEN-W_I){sgn}}, raw_i};
  assign imm_s = {{(XLEN-W_S){sgn}}, raw_s};
  assign imm_b = {{(XLEN-W_B){sgn}}, raw_b};
  assign imm_u = {{(XLEN-W_U){sgn}}, raw_u};
  assign imm_j = {{(XLEN-W_J){sgn}}, raw_j};
endmodule

module rv_imm_extract_chk #(
  parameter int XLEN = 64
) (
  input logic [31:0]     iw,
  input logic [XLEN-1:0] imm_i,
  input logic [XLEN-1:0] imm_s,
  input logic [XLEN-1:0] imm_b,
  input logic [XLEN-1:0] imm_u,
  input logic [XLEN-1:0] imm_j
);
  always_comb begin
    if (!$isunknown(iw)) begin
      p_s_shares_i_upper_r2: assert (imm_s[XLEN-1:5] == imm_i[XLEN-1:5]);
      p_b_lsb_zero_r3:       assert (imm_b[0] == 1'b0);
      p_b_mid_from_s_r3:     assert (imm_b[10:1] == imm_s[10:1]);
      p_b_bit11_r3:          assert (imm_b[11] == imm_s[0]);
      p_u_low_zero_r4:       assert (imm_u[11:0] == 12'd0);
      p_j_lsb_zero_r5:       assert (imm_j[0] == 1'b0);
      p_j_mid_from_i_r5:     assert (imm_j[10:1] == imm_i[10:1]);
      p_j_bit11_r5:          assert (imm_j[11] == imm_i[0]);
      p_j_upper_from_u_r5:   assert (imm_j[19:12] == imm_u[19:12]);
      p_sign_agree_r6:       assert (imm_i[XLEN-1] == imm_s[XLEN-1] &&
                                     imm_b[XLEN-1] == imm_u[XLEN-1] &&
                                     imm_j[XLEN-1] == imm_i[XLEN-1]);
      p_sign_src_r6:         assert (imm_u[XLEN-1] == iw[31]);
    end
  end
endmodule

bind rv_imm_extract rv_imm_extract_chk #(.XLEN(XLEN)) u_chk (
  .iw(iw), .imm_i(imm_i), .imm_s(imm_s), .imm_b(imm_b),
  .imm_u(imm_u), .imm_j(imm_j)
);

// File: tb/rv_imm_extract_tb.sv
module rv_imm_extract_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int NV = 10;

  localparam logic [31:0] V_IW [NV] = '{
    32'h0000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0080, 32'h0010_0000,
    32'h0000_0100, 32'h0000_1000, 32'h0020_0000, 32'h0200_0000, 32'hFFFF_FFFF};
  localparam logic [63:0] V_I [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_F800, 64'h7FF, 64'h0, 64'h1,
    64'h0, 64'h0, 64'h2, 64'h20, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_S [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_F800, 64'h7FF, 64'h1, 64'h0,
    64'h2, 64'h0, 64'h0, 64'h20, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_B [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_F000, 64'hFFE, 64'h800, 64'h0,
    64'h2, 64'h0, 64'h0, 64'h20, 64'hFFFF_FFFF_FFFF_FFFE};
  localparam logic [63:0] V_U [NV] = '{
    64'h0, 64'hFFFF_FFFF_8000_0000, 64'h7FFF_F000, 64'h0, 64'h10_0000,
    64'h0, 64'h1000, 64'h20_0000, 64'h200_0000, 64'hFFFF_FFFF_FFFF_F000};
  localparam logic [63:0] V_J [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFF0_0000, 64'hF_FFFE, 64'h0, 64'h800,
    64'h0, 64'h1000, 64'h2, 64'h20, 64'hFFFF_FFFF_FFFF_FFFE};

  logic clk = 1'b0;
  logic [31:0] iw;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv_imm_extract #(.XLEN(XLEN)) u_dut (
    .iw(iw), .imm_i(imm_i), .imm_s(imm_s), .imm_b(imm_b),
    .imm_u(imm_u), .imm_j(imm_j));

  function automatic logic [63:0] sx(input logic [63:0] v, input int top);
    logic [63:0] r;
    for (int k = 0; k < 64; k++) r[k] = (k <= top) ? v[k] : v[top];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s iw=%h actual=%h expected=%h", req, iw, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    iw = w;
    #1;
  endtask

  task automatic model_check(input string tag);
    logic [63:0] e;
    e = 0; e[11:0] = iw[31:20];                                   chk({tag, " R1"}, imm_i, sx(e, 11));
    e = 0; e[11:5] = iw[31:25]; e[4:0] = iw[11:7];                chk({tag, " R2"}, imm_s, sx(e, 11));
    e = 0; e[12] = iw[31]; e[11] = iw[7]; e[10:5] = iw[30:25];
    e[4:1] = iw[11:8];                                            chk({tag, " R3"}, imm_b, sx(e, 12));
    e = 0; e[31:12] = iw[31:12];                                  chk({tag, " R4"}, imm_u, sx(e, 31));
    e = 0; e[20] = iw[31]; e[19:12] = iw[19:12]; e[11] = iw[20];
    e[10:1] = iw[30:21];                                          chk({tag, " R5"}, imm_j, sx(e, 20));
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [63:0] si, ss, sb, su, sj;
    iw = 32'h0;
    #1;
    // zero word: all outputs zero (R1..R5)
    chk("R1 zero", imm_i, 64'h0);
    chk("R4 zero", imm_u, 64'h0);

    for (int n = 0; n < NV; n++) begin
      apply(V_IW[n]);
      chk("R1 table", imm_i, V_I[n]);
      chk("R2 table", imm_s, V_S[n]);
      chk("R3 table", imm_b, V_B[n]);
      chk("R4 table", imm_u, V_U[n]);
      chk("R5 table", imm_j, V_J[n]);
    end

    // R6: sign bit alone fills every upper bit
    apply(32'h8000_0000);
    chk("R6 upper i", {52'h0, imm_i[63:12] == {52{1'b1}}}, 64'h1);
    chk("R6 upper j", {43'h0, imm_j[63:21] == {43{1'b1}}}, 64'h1);

    // R7: opcode bits do not change any output
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr);
      si = imm_i; ss = imm_s; sb = imm_b; su = imm_u; sj = imm_j;
      apply(lfsr ^ {25'h0, lfsr[13:7] | 7'h01});
      chk("R7 opcode i", imm_i, si);
      chk("R7 opcode s", imm_s, ss);
      chk("R7 opcode b", imm_b, sb);
      chk("R7 opcode u", imm_u, su);
      chk("R7 opcode j", imm_j, sj);
    end

    // R8: outputs follow the word with no clock edge in between
    @(negedge clk);
    iw = 32'hFFFF_FFFF;
    #1;
    iw = 32'h0010_0000;
    #0.1;
    chk("R8 same step i", imm_i, 64'h1);
    chk("R8 same step j", imm_j, 64'h800);

    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr);
      model_check("sweep");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule